// File: doc/BRIEF.md
# Timed Event Code Sequencer

This block plays out a stored list of 8-bit event codes, each one released at a programmed 32-bit time offset measured from a trigger. A host fills the sequence memory through a plain write port. Each slot holds a timestamp and a code. Once the sequencer is triggered, a time counter starts from zero and advances at a prescaled fraction of the event clock. The slot under the read pointer is compared against that counter, and its code goes out with a one-cycle valid strobe when the counter reaches the slot's timestamp.

The trigger comes from one of four selectable sources: a software strobe, an external input, a counter output, or a mains line-synchronisation input passed through a programmable edge divider. Two code values are reserved. One marks an empty slot that is skipped without output. The other marks the end of the list. At that marker the sequencer either returns to idle and replays from slot 0 on the next trigger, or halts and ignores triggers until the host writes the memory again. An optional trigger code can be emitted at the moment the sequence starts.

Top module: `timed_event_seq`

## Requirements
- R1: A write with `wr_en` high stores `wr_stamp` and `wr_code` at `wr_addr` in a 2048-slot memory; the stored pair is what later playback emits, and rewriting a slot changes the played code.
- R2: While idle, a trigger from the selected source starts a run: the time counter and the read pointer restart at 0, and `busy` is high in the cycle after the triggering clock edge.
- R3: With prescaler value P (the counter advances once every P+1 clocks), slots are played in address order from slot 0, and the slot whose timestamp is s is emitted when the counter first reaches at least s. A slot with s greater than the previous timestamp therefore has `ev_valid` high in cycle s*(P+1)+1 after the trigger edge (cycle 0 is the one right after that edge). A slot whose timestamp equals the previous one is emitted in the following cycle.
- R4: A slot with code 0x00 is skipped: it advances the pointer and produces no `ev_valid`.
- R5: A slot with code 0x7F ends the run without output. When `recycle` is 1, `busy` drops and the next trigger replays the list from slot 0 with the same timing.
- R6: When `recycle` is 0, the end slot halts the sequencer. Triggers are then ignored (no `busy`, no `ev_valid`) until any memory write re-arms it to idle.
- R7: `trig_sel` picks the source: 0 the software strobe, 1 the external input, 2 the counter output, 3 the divided line-sync input. Rising edges on sources that are not selected have no effect.
- R8: The line-sync path fires a trigger on every (D+1)-th rising edge of `line_sync`, where D is `line_div` (ratios /1 to /256).
- R9: If `trig_code_en` is 1, `trig_code` is emitted with `ev_valid` in cycle 0 after the trigger edge. If it is 0, nothing is emitted in that cycle.
- R10: A trigger that arrives while `busy` is high is ignored, and the running sequence continues unchanged.
- R11: `ev_valid` is a strobe carrying at most one code per clock, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Memory write strobe |
| wr_addr | input | 11 | Slot address to write |
| wr_stamp | input | 32 | Timestamp to store |
| wr_code | input | 8 | Event code to store |
| trig_sel | input | 2 | Trigger source select (0 sw, 1 ext, 2 counter, 3 line) |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | External trigger input |
| mxc_trig | input | 1 | Counter output trigger input |
| line_sync | input | 1 | Mains line-synchronisation input |
| line_div | input | 8 | Line-sync divide value D, ratio D+1 |
| presc | input | 16 | Time prescaler value P, period P+1 clocks |
| recycle | input | 1 | 1: return to idle at end slot, 0: halt |
| trig_code_en | input | 1 | Emit trig_code at sequence start |
| trig_code | input | 8 | Code sent at sequence start |
| ev_valid | output | 1 | Event code valid strobe |
| ev_code | output | 8 | Emitted event code |
| busy | output | 1 | Sequence running |

## Verification
A stale read pointer or a time counter that is not cleared at the trigger shows up as codes out of order or shifted in time. Because the bench compares every cycle of a run against the s*(P+1)+1 schedule, such an error appears at the first scheduled slot, within a few clocks of the trigger. A wrong end-of-list state shows up as `busy` failing to fall in the cycle after the end slot's time, or, in halt mode, as a trigger that is accepted when it should be ignored. A miscounting line divider appears on the very edge at which the trigger should or should not fire.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int TS_W   = 32;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
    localparam logic [CODE_W-1:0] CODE_END  = 8'h7F;

    typedef struct packed {
        logic [TS_W-1:0]   stamp;
        logic [CODE_W-1:0] code;
    } seq_entry_t;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_MXC  = 2'd2,
        SRC_LINE = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    function automatic logic code_emits(input logic [CODE_W-1:0] c);
        return (c != CODE_NULL) && (c != CODE_END);
    endfunction

endpackage

// File: rtl/seq_mem.sv
module seq_mem
    import seq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  seq_entry_t    wr_data,
    input  logic [AW-1:0] rd_addr,
    output seq_entry_t    rd_data
);

    seq_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R1: the slot just written holds the written pair
    p_write_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/seq_trig.sv
module seq_trig
    import seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel,
    input  logic             sw_in,
    input  logic             ext_in,
    input  logic             mxc_in,
    input  logic             line_in,
    input  logic [DIV_W-1:0] line_div,
    output logic             trig
);

    localparam int NSRC = 4;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] rise;
    logic [DIV_W-1:0] line_cnt;
    logic line_fire;

    assign raw = {line_in, mxc_in, ext_in, sw_in};

    for (genvar i = 0; i < NSRC; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) raw_q[i] <= 1'b0;
            else     raw_q[i] <= raw[i];
        end
        assign rise[i] = raw[i] & ~raw_q[i];
    end

    assign line_fire = rise[SRC_LINE] && (line_cnt == line_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
        end else if (rise[SRC_LINE]) begin
            line_cnt <= line_fire ? '0 : line_cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            SRC_SW:   trig = rise[SRC_SW];
            SRC_EXT:  trig = rise[SRC_EXT];
            SRC_MXC:  trig = rise[SRC_MXC];
            default:  trig = line_fire;
        endcase
    end

    // R8: a divided line-sync trigger restarts the edge count
    p_line_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        line_fire |=> (line_cnt == '0));

endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PS_W  = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              rearm,
    input  logic [PS_W-1:0]   presc,
    input  logic              recycle,
    input  logic              trig_code_en,
    input  logic [CODE_W-1:0] trig_code,
    input  seq_entry_t        entry,
    output logic [AW-1:0]     rd_addr,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              busy
);

    seq_state_e       state;
    logic [AW-1:0]    ptr;
    logic [TS_W-1:0]  tcount;
    logic [PS_W-1:0]  pcount;
    logic             hit;
    logic             last;

    assign rd_addr = ptr;
    assign busy    = (state == ST_RUN);
    assign hit     = busy && (tcount >= entry.stamp);
    assign last    = (ptr == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            tcount   <= '0;
            pcount   <= '0;
            ev_valid <= 1'b0;
            ev_code  <= '0;
        end else begin
            ev_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state  <= ST_RUN;
                        ptr    <= '0;
                        tcount <= '0;
                        pcount <= '0;
                        if (trig_code_en) begin
                            ev_valid <= 1'b1;
                            ev_code  <= trig_code;
                        end
                    end
                end
                ST_RUN: begin
                    if (pcount == presc) begin
                        pcount <= '0;
                        tcount <= tcount + 1'b1;
                    end else begin
                        pcount <= pcount + 1'b1;
                    end
                    if (hit) begin
                        if (code_emits(entry.code)) begin
                            ev_valid <= 1'b1;
                            ev_code  <= entry.code;
                        end
                        if (entry.code == CODE_END || last) begin
                            state <= recycle ? ST_IDLE : ST_HALT;
                            ptr   <= '0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                default: begin
                    if (rearm) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: a new run starts from slot 0 at time 0
    p_start_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tcount == '0 && ptr == '0));

    // R3: the pointer only holds or steps forward by one during a run
    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));

    // R5: a finished run leaves the pointer at slot 0
    p_end_ptr_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ptr == '0));

    // R6: a halted sequencer stays idle-less until a write re-arms it
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !rearm) |=> !busy);

endmodule

// File: rtl/timed_event_seq.sv
module timed_event_seq
    import seq_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PS_W  = 16,
    parameter int DIV_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TS_W-1:0]   wr_stamp,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [1:0]        trig_sel,
    input  logic              sw_trig,
    input  logic              ext_trig,
    input  logic              mxc_trig,
    input  logic              line_sync,
    input  logic [DIV_W-1:0]  line_div,
    input  logic [PS_W-1:0]   presc,
    input  logic              recycle,
    input  logic              trig_code_en,
    input  logic [CODE_W-1:0] trig_code,
    output logic              ev_valid,
    output logic [CODE_W-1:0] ev_code,
    output logic              busy
);

    seq_entry_t    wr_data;
    seq_entry_t    rd_data;
    logic [AW-1:0] rd_addr;
    logic          trig;

    assign wr_data = '{stamp: wr_stamp, code: wr_code};

    seq_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    seq_trig #(.DIV_W(DIV_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .sel      (trig_sel),
        .sw_in    (sw_trig),
        .ext_in   (ext_trig),
        .mxc_in   (mxc_trig),
        .line_in  (line_sync),
        .line_div (line_div),
        .trig     (trig)
    );

    seq_core #(.DEPTH(DEPTH), .PS_W(PS_W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .trig         (trig),
        .rearm        (wr_en),
        .presc        (presc),
        .recycle      (recycle),
        .trig_code_en (trig_code_en),
        .trig_code    (trig_code),
        .entry        (rd_data),
        .rd_addr      (rd_addr),
        .ev_valid     (ev_valid),
        .ev_code      (ev_code),
        .busy         (busy)
    );

    // R11: the valid strobe only accompanies a real code
    p_valid_code_r11: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_code != CODE_NULL));

endmodule

// File: tb/sim_timed_event_seq.sv
module sim_timed_event_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [10:0] wr_addr;
    logic [31:0] wr_stamp;
    logic [7:0]  wr_code;
    logic [1:0]  trig_sel;
    logic        sw_trig, ext_trig, mxc_trig, line_sync;
    logic [7:0]  line_div;
    logic [15:0] presc;
    logic        recycle, trig_code_en;
    logic [7:0]  trig_code;
    logic        ev_valid;
    logic [7:0]  ev_code;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic       ev_exp [64];
    logic [7:0] ec_exp [64];
    logic       cv [64];
    logic [7:0] cc [64];
    logic       cb [64];

    always #5 clk = ~clk;

    timed_event_seq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_stamp(wr_stamp), .wr_code(wr_code), .trig_sel(trig_sel),
        .sw_trig(sw_trig), .ext_trig(ext_trig), .mxc_trig(mxc_trig),
        .line_sync(line_sync), .line_div(line_div), .presc(presc),
        .recycle(recycle), .trig_code_en(trig_code_en), .trig_code(trig_code),
        .ev_valid(ev_valid), .ev_code(ev_code), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_entry(input int addr, input int stamp, input logic [7:0] code);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(addr); wr_stamp = 32'(stamp); wr_code = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pulse one source; returns at the sample point of cycle 0
    task automatic fire(input int which);
        @(negedge clk);
        case (which)
            0: sw_trig = 1'b1;
            1: ext_trig = 1'b1;
            2: mxc_trig = 1'b1;
            default: line_sync = 1'b1;
        endcase
        @(negedge clk);
        sw_trig = 1'b0; ext_trig = 1'b0; mxc_trig = 1'b0; line_sync = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // capture from cycle 0; optional software retrigger after sample k
    task automatic capture(input int n, input int retrig_at);
        for (int i = 0; i < n; i++) begin
            cv[i] = ev_valid; cc[i] = ev_code; cb[i] = busy;
            if (i == retrig_at) sw_trig = 1'b1;
            if (i == retrig_at + 1) sw_trig = 1'b0;
            if (i < n - 1) @(negedge clk);
        end
        sw_trig = 1'b0;
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 64; i++) begin ev_exp[i] = 1'b0; ec_exp[i] = 8'h00; end
    endtask

    task automatic compare_run(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(cv[i] == ev_exp[i], req, $sformatf("ev_valid cycle %0d", i), 32'(cv[i]), 32'(ev_exp[i]));
            if (ev_exp[i])
                chk(cc[i] == ec_exp[i], req, $sformatf("ev_code cycle %0d", i), 32'(cc[i]), 32'(ec_exp[i]));
        end
    endtask

    // expected schedule for the base list, prescaler 0, trigger code on
    task automatic exp_base_p0();
        clear_exp();
        ev_exp[0] = 1; ec_exp[0] = 8'h11;
        ev_exp[1] = 1; ec_exp[1] = 8'h20;
        ev_exp[4] = 1; ec_exp[4] = 8'h2A;
        ev_exp[5] = 1; ec_exp[5] = 8'h24;
        ev_exp[8] = 1; ec_exp[8] = 8'h2C;
    endtask

    task automatic t_reset();
        chk(ev_valid == 1'b0, "R11", "ev_valid after reset", 32'(ev_valid), 0);
        chk(busy == 1'b0, "R2", "busy after reset", 32'(busy), 0);
    endtask

    task automatic t_basic_play();
        write_entry(0, 0, 8'h20);
        write_entry(1, 3, 8'h2A);
        write_entry(2, 3, 8'h24);
        write_entry(3, 5, 8'h00);
        write_entry(4, 7, 8'h2C);
        write_entry(5, 9, 8'h7F);
        presc = 16'd0; recycle = 1'b1; trig_code_en = 1'b1; trig_code = 8'h11; trig_sel = 2'd0;
        fire(0);
        capture(14, -5);
        exp_base_p0();
        compare_run("R3 R4 R9 R1", 14);
        chk(cb[0] == 1'b1, "R2", "busy in cycle 0", 32'(cb[0]), 1);
        chk(cb[9] == 1'b1, "R5", "busy before end slot", 32'(cb[9]), 1);
        chk(cb[10] == 1'b0, "R5", "busy after end slot", 32'(cb[10]), 0);
    endtask

    task automatic t_recycle_replay();
        fire(0);
        capture(14, -5);
        exp_base_p0();
        compare_run("R5", 14);
        chk(cb[10] == 1'b0, "R5", "busy after replay end", 32'(cb[10]), 0);
    endtask

    task automatic t_prescaled();
        write_entry(4, 7, 8'h2D);
        presc = 16'd2; trig_code_en = 1'b0;
        fire(0);
        capture(32, -5);
        clear_exp();
        ev_exp[1] = 1;  ec_exp[1] = 8'h20;
        ev_exp[10] = 1; ec_exp[10] = 8'h2A;
        ev_exp[11] = 1; ec_exp[11] = 8'h24;
        ev_exp[22] = 1; ec_exp[22] = 8'h2D;
        compare_run("R3 R9 R1", 32);
        chk(cb[27] == 1'b1, "R3", "busy before end, P=2", 32'(cb[27]), 1);
        chk(cb[28] == 1'b0, "R3", "busy after end, P=2", 32'(cb[28]), 0);
        write_entry(4, 7, 8'h2C);
        presc = 16'd0; trig_code_en = 1'b1;
    endtask

    task automatic t_retrigger_ignored();
        fire(0);
        capture(14, 3);
        exp_base_p0();
        compare_run("R10", 14);
        chk(cb[10] == 1'b0, "R10", "busy after end with retrigger", 32'(cb[10]), 0);
    endtask

    task automatic t_source_select();
        trig_sel = 2'd1;
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7", "sw ignored when ext selected", 32'(busy), 0);
        mxc_trig = 1'b1;
        @(negedge clk); mxc_trig = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7", "counter ignored when ext selected", 32'(busy), 0);
        fire(1);
        chk(busy == 1'b1, "R7", "ext starts run", 32'(busy), 1);
        chk(ev_valid == 1'b1 && ev_code == 8'h11, "R9", "trigger code on ext", 32'(ev_code), 32'h11);
        wait_cycles(12);
        trig_sel = 2'd2;
        fire(2);
        chk(busy == 1'b1, "R7", "counter starts run", 32'(busy), 1);
        wait_cycles(12);
    endtask

    task automatic t_line_divider();
        trig_sel = 2'd3; line_div = 8'd2;
        fire(3);
        chk(busy == 1'b0, "R8", "line edge 1 of 3", 32'(busy), 0);
        fire(3);
        chk(busy == 1'b0, "R8", "line edge 2 of 3", 32'(busy), 0);
        fire(3);
        chk(busy == 1'b1, "R8", "line edge 3 of 3 triggers", 32'(busy), 1);
        wait_cycles(12);
        line_div = 8'd0;
        fire(3);
        chk(busy == 1'b1, "R8", "line /1 triggers on each edge", 32'(busy), 1);
        wait_cycles(12);
    endtask

    task automatic t_stop_mode();
        trig_sel = 2'd0; recycle = 1'b0;
        fire(0);
        wait_cycles(12);
        chk(busy == 1'b0, "R6", "run finished in halt mode", 32'(busy), 0);
        fire(0);
        chk(busy == 1'b0, "R6", "trigger ignored while halted", 32'(busy), 0);
        chk(ev_valid == 1'b0, "R6", "no code while halted", 32'(ev_valid), 0);
        write_entry(5, 9, 8'h7F);
        fire(0);
        chk(busy == 1'b1, "R6", "write re-arms", 32'(busy), 1);
        chk(ev_valid == 1'b1 && ev_code == 8'h11, "R6", "code after re-arm", 32'(ev_code), 32'h11);
        wait_cycles(12);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_stamp = '0; wr_code = '0;
        trig_sel = 2'd0; sw_trig = 1'b0; ext_trig = 1'b0; mxc_trig = 1'b0;
        line_sync = 1'b0; line_div = 8'd0; presc = 16'd0; recycle = 1'b1;
        trig_code_en = 1'b0; trig_code = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_play();
        t_recycle_replay();
        t_prescaled();
        t_retrigger_ignored();
        t_source_select();
        t_line_divider();
        t_stop_mode();
        finished = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            summary();
        end
    end

endmodule